// File: doc/BRIEF.md
# Two-Domain Reset Sequencer with Cause Latch

This block generates the reset signals for a chip with two supply domains. One supply domain is an always-on pad domain clocked by a slow RC oscillator. The other is a core domain clocked by a fast crystal. Two analog comparators report power-on conditions, one per supply. The sequencer first releases the always-on reset, once the pad comparator has cleared and the slow clock has proven itself with three pulses. It then releases the core reset, once the core comparator has cleared and 1024 crystal edges have passed.

Four event requests arrive as single-cycle pulses in the crystal domain: watchdog expiry, program-counter rollover, software request and core supply dip. Each one re-enters core reset and restarts the crystal count, and leaves the always-on domain running. A one-hot cause register sits in the always-on domain. It tells software after reset why the last reset happened, and it keeps its value through core-only resets.

Top module: `reset_seq`

## Requirements
- R1: While `pad_por` is high, `aon_rst` is high; it asserts without waiting for any clock edge.
- R2: After `pad_por` falls, `aon_rst` falls on the 5th rising edge of `rc_clk` (two synchronizer edges plus three counted pulses) and stays high through the 4th.
- R3: `core_rst` is high whenever `core_por` or `aon_rst` is high, asserting without waiting for a clock edge.
- R4: After the later of `core_por` and `aon_rst` falls, `core_rst` falls on the 1026th rising edge of `xtal_clk` (two synchronizer edges plus 1024 counted edges).
- R5: An event pulse sampled high at a `xtal_clk` edge forces `core_rst` high after that edge and restarts the count, so `core_rst` falls on the 1024th edge after the last event edge; `aon_rst` is not affected.
- R6: If `core_por` rises during the count, the count is discarded and the full R4 sequence runs again from its next fall.
- R7: `rst_cause` is one-hot with bit 0 power-on, bit 1 watchdog, bit 2 PC rollover, bit 3 software and bit 4 core dip; whenever `pad_por` is high it reads 5'b00001.
- R8: When several events are sampled in the same cycle, only the lowest-numbered of their cause bits is recorded.
- R9: `core_por` activity does not change `rst_cause`; the cause of the last event survives a core-only reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rc_clk | input | 1 | Slow RC oscillator clock, always-on domain |
| xtal_clk | input | 1 | Fast crystal clock, core domain |
| pad_por | input | 1 | Pad-supply power-on indication, high while supply is low |
| core_por | input | 1 | Core-supply power-on indication, high while supply is low |
| wdog_evt | input | 1 | Watchdog expiry pulse (xtal domain) |
| pcroll_evt | input | 1 | Program-counter rollover pulse (xtal domain) |
| sw_evt | input | 1 | Software reset request pulse (xtal domain) |
| dip_evt | input | 1 | Core supply dip pulse (xtal domain) |
| aon_rst | output | 1 | Always-on domain reset, active high |
| core_rst | output | 1 | Core domain reset, active high |
| rst_cause | output | 5 | One-hot cause of the most recent reset |

## Verification
The bench samples both resets one edge before and one edge after each expected release. An off-by-one in the synchronizer depth or in the pulse and edge counters therefore shows up as an early or late release. Two events are issued 600 cycles apart, and a release 1024 edges after the first event exposes a counter that is not restarted. The bench also pulses `core_por` in the middle of a count. A design that only pauses the counter instead of clearing it releases too early, and a design that clears the cause on core reset loses the logged watchdog code. Events are combined several at a time to catch an inverted priority. The pad comparator is raised while a non-power-on cause is held, to catch a cause register that is not forced back to the power-on code.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;

  localparam int CAUSE_W = 5;
  localparam int EVT_W   = CAUSE_W - 1;

  // Bit positions in the cause register; neighbours decode these.
  localparam int CAUSE_POR  = 0;
  localparam int CAUSE_WDOG = 1;
  localparam int CAUSE_PC   = 2;
  localparam int CAUSE_SW   = 3;
  localparam int CAUSE_DIP  = 4;

  typedef logic [CAUSE_W-1:0] cause_t;
  typedef logic [EVT_W-1:0]   evt_t;

  localparam cause_t CAUSE_POR_CODE = cause_t'(1) << CAUSE_POR;

endpackage

// File: rtl/rst_sync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain_q <= '1;
    else      chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_out = chain_q[STAGES-1];

endmodule

// File: rtl/aon_seq.sv
// Always-on domain release: synchronized pad indication, then PULSES rc edges.
module aon_seq #(
  parameter int SYNC   = 2,
  parameter int PULSES = 3
) (
  input  logic rc_clk,
  input  logic pad_por,
  output logic aon_rst
);

  localparam int PW = $clog2(PULSES + 1);

  logic          hold;
  logic [PW-1:0] pulse_q;
  logic [PW-1:0] pulse_nxt;
  logic          rst_q;

  rst_sync #(.STAGES(SYNC)) u_sync (
    .clk    (rc_clk),
    .arst   (pad_por),
    .rst_out(hold)
  );

  assign pulse_nxt = pulse_q + 1'b1;

  always_ff @(posedge rc_clk or posedge pad_por) begin
    if (pad_por) begin
      pulse_q <= '0;
      rst_q   <= 1'b1;
    end else if (!hold && pulse_q != PW'(PULSES)) begin
      pulse_q <= pulse_nxt;
      rst_q   <= (pulse_nxt != PW'(PULSES));
    end
  end

  assign aon_rst = rst_q;

endmodule

// File: rtl/core_seq.sv
// Core domain release: synchronized hard reset, then EDGES crystal edges.
// Events restart the count synchronously.
module core_seq #(
  parameter int SYNC  = 2,
  parameter int EDGES = 1024
) (
  input  logic xtal_clk,
  input  logic hard_rst,
  input  logic evt_any,
  output logic core_rst
);

  localparam int CW = $clog2(EDGES + 1);

  logic          hold;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          rst_q;

  rst_sync #(.STAGES(SYNC)) u_sync (
    .clk    (xtal_clk),
    .arst   (hard_rst),
    .rst_out(hold)
  );

  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge xtal_clk or posedge hard_rst) begin
    if (hard_rst) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else if (evt_any) begin
      cnt_q <= '0;
      rst_q <= 1'b1;
    end else if (!hold && cnt_q != CW'(EDGES)) begin
      cnt_q <= cnt_nxt;
      rst_q <= (cnt_nxt != CW'(EDGES));
    end
  end

  assign core_rst = rst_q;

endmodule

// File: rtl/cause_log.sv
// Cause register in the always-on domain, clocked by the crystal.
module cause_log
  import reset_seq_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic   xtal_clk,
  input  logic   aon_rst,
  input  evt_t   evt,
  output cause_t cause
);

  logic   aon_x;
  evt_t   pick;
  cause_t cause_q;

  rst_sync #(.STAGES(SYNC)) u_aon_sync (
    .clk    (xtal_clk),
    .arst   (aon_rst),
    .rst_out(aon_x)
  );

  // Lowest-numbered event wins.
  always_comb begin
    pick = '0;
    for (int i = EVT_W - 1; i >= 0; i--) begin
      if (evt[i]) pick = evt_t'(1) << i;
    end
  end

  always_ff @(posedge xtal_clk or posedge aon_x) begin
    if (aon_x)     cause_q <= CAUSE_POR_CODE;
    else if (|evt) cause_q <= {pick, 1'b0};
  end

  assign cause = cause_q;

endmodule

// File: rtl/reset_seq.sv
module reset_seq
  import reset_seq_pkg::*;
#(
  parameter int SYNC   = 2,
  parameter int PULSES = 3,
  parameter int EDGES  = 1024
) (
  input  logic               rc_clk,
  input  logic               xtal_clk,
  input  logic               pad_por,
  input  logic               core_por,
  input  logic               wdog_evt,
  input  logic               pcroll_evt,
  input  logic               sw_evt,
  input  logic               dip_evt,
  output logic               aon_rst,
  output logic               core_rst,
  output logic [CAUSE_W-1:0] rst_cause
);

  evt_t evt;
  logic hard_rst;

  assign evt[CAUSE_WDOG-1] = wdog_evt;
  assign evt[CAUSE_PC-1]   = pcroll_evt;
  assign evt[CAUSE_SW-1]   = sw_evt;
  assign evt[CAUSE_DIP-1]  = dip_evt;

  aon_seq #(.SYNC(SYNC), .PULSES(PULSES)) u_aon (
    .rc_clk (rc_clk),
    .pad_por(pad_por),
    .aon_rst(aon_rst)
  );

  assign hard_rst = aon_rst | core_por;

  core_seq #(.SYNC(SYNC), .EDGES(EDGES)) u_core (
    .xtal_clk(xtal_clk),
    .hard_rst(hard_rst),
    .evt_any (|evt),
    .core_rst(core_rst)
  );

  cause_log #(.SYNC(SYNC)) u_cause (
    .xtal_clk(xtal_clk),
    .aon_rst (aon_rst),
    .evt     (evt),
    .cause   (rst_cause)
  );

endmodule

// File: rtl/reset_seq_chk.sv
module reset_seq_chk #(
  parameter int EDGES = 1024
) (
  input logic       xtal_clk,
  input logic       pad_por,
  input logic       core_por,
  input logic       wdog_evt,
  input logic       pcroll_evt,
  input logic       sw_evt,
  input logic       dip_evt,
  input logic       aon_rst,
  input logic       core_rst,
  input logic [4:0] rst_cause
);

  localparam int QW = $clog2(EDGES + 2);

  logic          armed;
  logic [QW-1:0] quiet;
  logic          any_evt;

  assign any_evt = wdog_evt | pcroll_evt | sw_evt | dip_evt;

  always_ff @(posedge xtal_clk) begin
    if (aon_rst) armed <= 1'b1;
    else if (armed !== 1'b1) armed <= 1'b0;
  end

  // Cycles since the last event or hard reset, saturating.
  always_ff @(posedge xtal_clk) begin
    if (any_evt || core_por || aon_rst) quiet <= '0;
    else if (quiet != QW'(EDGES + 1))   quiet <= quiet + 1'b1;
  end

  // R1 R7
  pad_hold_chk: assert property (@(posedge xtal_clk) disable iff (!armed)
    pad_por |-> (aon_rst && rst_cause == 5'b00001));

  // R3
  core_hold_chk: assert property (@(posedge xtal_clk) disable iff (!armed)
    (core_por || aon_rst) |-> core_rst);

  // R5
  evt_enter_chk: assert property (@(posedge xtal_clk) disable iff (!armed || aon_rst || core_por)
    any_evt |=> core_rst);

  // R4 R5
  release_gap_chk: assert property (@(posedge xtal_clk) disable iff (!armed)
    $fell(core_rst) |-> (quiet >= QW'(EDGES)));

  // R7
  cause_onehot_chk: assert property (@(posedge xtal_clk) disable iff (!armed)
    $onehot(rst_cause));

  // R8
  wdog_first_chk: assert property (@(posedge xtal_clk) disable iff (!armed || aon_rst || core_por)
    wdog_evt |=> rst_cause == 5'b00010);

endmodule

bind reset_seq reset_seq_chk #(.EDGES(EDGES)) u_chk (
  .xtal_clk  (xtal_clk),
  .pad_por   (pad_por),
  .core_por  (core_por),
  .wdog_evt  (wdog_evt),
  .pcroll_evt(pcroll_evt),
  .sw_evt    (sw_evt),
  .dip_evt   (dip_evt),
  .aon_rst   (aon_rst),
  .core_rst  (core_rst),
  .rst_cause (rst_cause)
);

// File: tb/test_reset_seq.sv
module test_reset_seq;

  logic       rc_clk = 1'b0;
  logic       xtal_clk = 1'b0;
  logic       pad_por = 1'b0;
  logic       core_por = 1'b0;
  logic       wdog_evt = 1'b0;
  logic       pcroll_evt = 1'b0;
  logic       sw_evt = 1'b0;
  logic       dip_evt = 1'b0;
  logic       aon_rst;
  logic       core_rst;
  logic [4:0] rst_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4  xtal_clk = ~xtal_clk;  // 125 MHz
  always #44 rc_clk   = ~rc_clk;

  reset_seq i_reset_seq (
    .rc_clk    (rc_clk),
    .xtal_clk  (xtal_clk),
    .pad_por   (pad_por),
    .core_por  (core_por),
    .wdog_evt  (wdog_evt),
    .pcroll_evt(pcroll_evt),
    .sw_evt    (sw_evt),
    .dip_evt   (dip_evt),
    .aon_rst   (aon_rst),
    .core_rst  (core_rst),
    .rst_cause (rst_cause)
  );

  // {event pattern {dip,sw,pc,wdog}, expected cause}
  localparam logic [8:0] VEC [8] = '{
    {4'b0001, 5'b00010},
    {4'b0010, 5'b00100},
    {4'b0100, 5'b01000},
    {4'b1000, 5'b10000},
    {4'b0110, 5'b00100},
    {4'b1111, 5'b00010},
    {4'b1100, 5'b01000},
    {4'b1010, 5'b00100}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // Pulse an event pattern for one crystal cycle; returns just after the sampling edge.
  task automatic pulse_evt(input logic [3:0] pat);
    @(negedge xtal_clk);
    {dip_evt, sw_evt, pcroll_evt, wdog_evt} = pat;
    @(negedge xtal_clk);
    {dip_evt, sw_evt, pcroll_evt, wdog_evt} = 4'b0000;
  endtask

  // After an event edge: released exactly on the 1024th following edge.
  task automatic expect_evt_release(input string req);
    repeat (1023) @(negedge xtal_clk);
    check(req, core_rst, 1'b1);
    @(negedge xtal_clk);
    check(req, core_rst, 1'b0);
  endtask

  task automatic expect_aon_release(input string req);
    repeat (4) @(negedge rc_clk);
    check(req, aon_rst, 1'b1);
    @(negedge rc_clk);
    check(req, aon_rst, 1'b0);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    #1;
    pad_por  = 1'b1;
    core_por = 1'b1;
    repeat (3) @(negedge rc_clk);
    check("R1", aon_rst, 1'b1);
    check("R3", core_rst, 1'b1);
    check("R7", rst_cause, 5'b00001);

    // Power-up: always-on release, then core release.
    pad_por = 1'b0;
    expect_aon_release("R2");
    check("R3", core_rst, 1'b1);
    @(negedge xtal_clk);
    core_por = 1'b0;
    repeat (1025) @(negedge xtal_clk);
    check("R4", core_rst, 1'b1);
    @(negedge xtal_clk);
    check("R4", core_rst, 1'b0);
    check("R7", rst_cause, 5'b00001);

    // Table walk: single and simultaneous events.
    for (int i = 0; i < 8; i++) begin
      pulse_evt(VEC[i][8:5]);
      check("R5", core_rst, 1'b1);
      check("R8", rst_cause, VEC[i][4:0]);
      check("R5", aon_rst, 1'b0);
      expect_evt_release("R5");
      check("R7", rst_cause, VEC[i][4:0]);
    end

    // A second event restarts the count.
    pulse_evt(4'b0100);
    repeat (600) @(negedge xtal_clk);
    pulse_evt(4'b0010);
    check("R7", rst_cause, 5'b00100);
    expect_evt_release("R5");

    // Core supply indication reasserts mid-count.
    pulse_evt(4'b0001);
    check("R7", rst_cause, 5'b00010);
    repeat (500) @(negedge xtal_clk);
    core_por = 1'b1;
    #1;
    check("R3", core_rst, 1'b1);
    repeat (3) @(negedge xtal_clk);
    core_por = 1'b0;
    repeat (1025) @(negedge xtal_clk);
    check("R6", core_rst, 1'b1);
    @(negedge xtal_clk);
    check("R6", core_rst, 1'b0);
    check("R9", rst_cause, 5'b00010);
    check("R9", aon_rst, 1'b0);

    // Pad supply drops again: power-on code replaces the logged cause.
    @(negedge xtal_clk);
    pad_por = 1'b1;
    #2;
    check("R1", aon_rst, 1'b1);
    check("R3", core_rst, 1'b1);
    check("R7", rst_cause, 5'b00001);
    @(negedge rc_clk);
    pad_por = 1'b0;
    expect_aon_release("R2");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule